// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block is the control register that a small processor core uses to run flash self-programming commands. Software writes a command bit together with the main enable bit. This opens a short armed window. A store-to-program-memory strobe from the core during that window starts the command. The commands are page erase, page write, lock-bit set and read re-enable of the rewritable section. If only the main enable is written, the strobe instead starts a page-buffer load.

Erase, write and lock operations go to the flash model through a one-cycle start pulse that carries a one-hot opcode and the page address. They end with a one-cycle done pulse. While an erase or write aimed at the rewritable section runs, a section-busy flag blocks reads from that section. A write to the non-rewritable section halts the core until it finishes. A ready interrupt is raised whenever the main enable bit is clear.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every register bit reads zero. Bit 5 of `reg_rdata` is reserved and reads zero even when software writes a one to it. Register layout: bit 7 interrupt enable, bit 6 section busy (read-only), bit 4 read re-enable, bit 3 lock set, bit 2 page write, bit 1 page erase, bit 0 main enable.
- R2: `irq` is high exactly when the interrupt enable bit is set, `irq_global_en` is high and the main enable bit is clear.
- R3: A register write with bit 0 set arms a window. A `spm_strobe` on any of the next four rising edges starts the command. If no strobe arrives by the fourth edge, the main enable bit and the command bits read zero after that edge, and a later strobe does nothing.
- R4: When several command bits are written together, only one is kept. The priority is erase (bit 1), then write (bit 2), then lock (bit 3), then read re-enable (bit 4). `flash_op` is one-hot: bit 0 erase, bit 1 write, bit 2 lock.
- R5: A done pulse while an operation runs clears the main enable bit and the command bits on that edge.
- R6: The start pulse presents `ptr_page` on `flash_page`. An erase or write with `ptr_page` below `RWW_PAGES` sets the section-busy bit in the same cycle as the start pulse.
- R7: A read re-enable command that has been started by a strobe clears the section-busy bit. A page-buffer load start (`buf_load` pulse) also clears it.
- R8: While an operation runs, register writes change only bit 7. A read re-enable written during an erase does not clear the section-busy bit, and neither does a later strobe.
- R9: A register write with bit 4 set while a page-buffer load is armed aborts the load. It pulses `buf_abort`, clears the register, and the next strobe gives no `buf_load`.
- R10: With lock set armed, an `lpm_strobe` on the first three edges of the window gives `lpm_hit` one cycle later. `lpm_data` is `fuse_bits` when `ptr_lsb` is 1 and `lock_bits` when it is 0. A load strobe on the fourth edge gives no hit.
- R11: `halt_core` is high while a page write to a page at or above `RWW_PAGES` runs, and low for erases and for rewritable-section writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| irq_global_en | input | 1 | Global interrupt flag of the core |
| irq | output | 1 | Ready interrupt |
| spm_strobe | input | 1 | Store-to-program-memory strobe |
| lpm_strobe | input | 1 | Load-from-program-memory strobe |
| ptr_page | input | 9 | Page part of the address pointer |
| ptr_lsb | input | 1 | Address pointer bit 0 |
| lock_bits | input | 8 | Current lock bits |
| fuse_bits | input | 8 | Current fuse bits |
| lpm_hit | output | 1 | Lock/fuse read result valid |
| lpm_data | output | 8 | Lock/fuse read result |
| flash_start | output | 1 | One-cycle operation start |
| flash_op | output | 3 | One-hot opcode: erase, write, lock |
| flash_page | output | 9 | Page of the started operation |
| flash_done | input | 1 | One-cycle operation completion |
| buf_load | output | 1 | Page-buffer load start pulse |
| buf_abort | output | 1 | Page-buffer load abort pulse |
| rww_busy | output | 1 | Rewritable section blocked for reading |
| halt_core | output | 1 | Core halt during non-rewritable write |

## Verification
Two situations are hard to reach from the ports. One is a read re-enable that arrives while an erase is still running. The other is an abort of a page-buffer load that is armed but not yet loaded. Each needs a precise sequence of register writes, strobes and done pulses. The bench reaches the first by starting an erase of a rewritable page, holding back the done pulse, and then writing and strobing the read re-enable. For the second it writes the main enable alone and then a word with bit 4 set before any strobe. A table of single commands, each run after a fresh reset with strobe delays from one to five cycles, covers the edges of the window and the priority order.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    localparam int REG_W      = 8;
    localparam int BIT_EN     = 0;
    localparam int BIT_RSVD   = 5;
    localparam int BIT_BUSY   = 6;
    localparam int BIT_IE     = 7;
    localparam int CMD_N      = 4;
    localparam int CMD_LSB    = 1;
    localparam int OP_N       = 3;
    // command slot indices inside the stored one-hot command
    localparam int C_ERASE    = 0;
    localparam int C_WRITE    = 1;
    localparam int C_LOCK     = 2;
    localparam int C_REEN     = 3;
endpackage

// File: rtl/fsp_cmd_pick.sv
module fsp_cmd_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N-1:0] seen;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i] = req[i] & ~seen[i];
        if (i < N - 1) begin : g_next
            assign seen[i+1] = seen[i] | req[i];
        end
    end
endmodule

// File: rtl/fsp_arm_window.sv
module fsp_arm_window #(
    parameter int WIN_CYC = 4,
    parameter int LPM_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic clear,
    output logic open_win,
    output logic lpm_open,
    output logic expire
);
    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIN_CYC);
    localparam logic [CNT_W-1:0] LPM_FLOOR = CNT_W'(WIN_CYC - LPM_CYC);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (arm) begin
            cnt_d = CNT_FULL;
        end else if (clear) begin
            cnt_d = '0;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign open_win = (cnt_q != '0);
    assign lpm_open = (cnt_q > LPM_FLOOR);
    assign expire   = (cnt_q == CNT_W'(1)) && !arm && !clear;

    p_win_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);
    p_win_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));
endmodule

// File: rtl/fsp_section_guard.sv
module fsp_section_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic set_busy,
    input  logic clr_busy,
    output logic busy
);
    logic busy_q, busy_d;

    always_comb begin
        busy_d = busy_q;
        if (set_busy)      busy_d = 1'b1;
        else if (clr_busy) busy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_d;
    end

    assign busy = busy_q;

    p_busy_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_busy |=> busy);
    p_busy_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy && !set_busy) |=> !busy);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fsp_pkg::*;
#(
    parameter int PAGE_W    = 9,
    parameter int RWW_PAGES = 448,
    parameter int WIN_CYC   = 4,
    parameter int LPM_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              irq_global_en,
    output logic              irq,
    input  logic              spm_strobe,
    input  logic              lpm_strobe,
    input  logic [PAGE_W-1:0] ptr_page,
    input  logic              ptr_lsb,
    input  logic [REG_W-1:0]  lock_bits,
    input  logic [REG_W-1:0]  fuse_bits,
    output logic              lpm_hit,
    output logic [REG_W-1:0]  lpm_data,
    output logic              flash_start,
    output logic [OP_N-1:0]   flash_op,
    output logic [PAGE_W-1:0] flash_page,
    input  logic              flash_done,
    output logic              buf_load,
    output logic              buf_abort,
    output logic              rww_busy,
    output logic              halt_core
);
    typedef struct packed {
        logic              ie;
        logic              en;
        logic [CMD_N-1:0]  cmd;
        logic              run;
        logic              ld_arm;
        logic              start;
        logic [OP_N-1:0]   op;
        logic [PAGE_W-1:0] page;
        logic              tgt_rww;
        logic              lhit;
        logic [REG_W-1:0]  ldata;
        logic              bload;
        logic              babort;
    } ctl_t;

    ctl_t s_q, s_d;

    logic             win_arm, win_clear, win_open, win_lpm, win_expire;
    logic             g_set, g_clr, busy;
    logic [CMD_N-1:0] picked;
    logic             page_in_rww;
    logic             prog_cmd;

    fsp_cmd_pick #(.N(CMD_N)) u_pick (
        .req   (reg_wdata[CMD_LSB +: CMD_N]),
        .grant (picked)
    );

    fsp_arm_window #(.WIN_CYC(WIN_CYC), .LPM_CYC(LPM_CYC)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (win_arm),
        .clear    (win_clear),
        .open_win (win_open),
        .lpm_open (win_lpm),
        .expire   (win_expire)
    );

    fsp_section_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_busy (g_set),
        .clr_busy (g_clr),
        .busy     (busy)
    );

    assign page_in_rww = int'(ptr_page) < RWW_PAGES;
    assign prog_cmd    = s_q.cmd[C_ERASE] | s_q.cmd[C_WRITE];

    always_comb begin
        s_d        = s_q;
        s_d.start  = 1'b0;
        s_d.lhit   = 1'b0;
        s_d.bload  = 1'b0;
        s_d.babort = 1'b0;
        win_arm    = 1'b0;
        win_clear  = 1'b0;
        g_set      = 1'b0;
        g_clr      = 1'b0;

        if (reg_we && s_q.run) begin
            s_d.ie = reg_wdata[BIT_IE];
        end else if (reg_we) begin
            s_d.ie = reg_wdata[BIT_IE];
            if (s_q.en && s_q.ld_arm && reg_wdata[CMD_LSB + C_REEN]) begin
                s_d.babort = 1'b1;
                s_d.en     = 1'b0;
                s_d.cmd    = '0;
                s_d.ld_arm = 1'b0;
                win_clear  = 1'b1;
            end else if (reg_wdata[BIT_EN]) begin
                s_d.en     = 1'b1;
                s_d.cmd    = picked;
                s_d.ld_arm = (picked == '0);
                win_arm    = 1'b1;
            end else begin
                s_d.en     = 1'b0;
                s_d.cmd    = '0;
                s_d.ld_arm = 1'b0;
                win_clear  = 1'b1;
            end
        end else if (win_open && spm_strobe) begin
            win_clear = 1'b1;
            if (prog_cmd || s_q.cmd[C_LOCK]) begin
                s_d.start   = 1'b1;
                s_d.op      = s_q.cmd[OP_N-1:0];
                s_d.page    = ptr_page;
                s_d.run     = 1'b1;
                s_d.tgt_rww = page_in_rww;
                g_set       = prog_cmd && page_in_rww;
            end else if (s_q.cmd[C_REEN]) begin
                g_clr   = 1'b1;
                s_d.en  = 1'b0;
                s_d.cmd = '0;
            end else begin
                s_d.bload  = 1'b1;
                g_clr      = 1'b1;
                s_d.en     = 1'b0;
                s_d.ld_arm = 1'b0;
            end
        end else if (win_expire) begin
            s_d.en     = 1'b0;
            s_d.cmd    = '0;
            s_d.ld_arm = 1'b0;
        end

        if (s_q.run && flash_done) begin
            s_d.run = 1'b0;
            s_d.en  = 1'b0;
            s_d.cmd = '0;
        end

        if (lpm_strobe && win_lpm && s_q.cmd[C_LOCK] && !s_q.run) begin
            s_d.lhit  = 1'b1;
            s_d.ldata = ptr_lsb ? fuse_bits : lock_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reg_rdata   = {s_q.ie, busy, 1'b0, s_q.cmd, s_q.en};
    assign irq         = s_q.ie & irq_global_en & ~s_q.en;
    assign lpm_hit     = s_q.lhit;
    assign lpm_data    = s_q.ldata;
    assign flash_start = s_q.start;
    assign flash_op    = s_q.op;
    assign flash_page  = s_q.page;
    assign buf_load    = s_q.bload;
    assign buf_abort   = s_q.babort;
    assign rww_busy    = busy;
    assign halt_core   = s_q.run & s_q.op[C_WRITE] & ~s_q.tgt_rww;

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[BIT_RSVD] == 1'b0);
    p_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_rdata[BIT_IE] && !reg_rdata[BIT_EN]));
    p_start_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flash_start |-> $onehot(flash_op));
    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && flash_done) |=> !reg_rdata[BIT_EN]);
    p_run_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !flash_done) |=> $stable(reg_rdata[BIT_BUSY:0]));
    p_lpm_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_hit |-> $past(reg_rdata[CMD_LSB + C_LOCK]));
    p_halt_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_core |-> (reg_rdata[BIT_EN] && reg_rdata[CMD_LSB + C_WRITE]));
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_global_en = 1'b0;
    logic       irq;
    logic       spm_strobe = 1'b0;
    logic       lpm_strobe = 1'b0;
    logic [8:0] ptr_page = 9'd0;
    logic       ptr_lsb = 1'b0;
    logic [7:0] lock_bits = 8'h3C;
    logic [7:0] fuse_bits = 8'hA5;
    logic       lpm_hit;
    logic [7:0] lpm_data;
    logic       flash_start;
    logic [2:0] flash_op;
    logic [8:0] flash_page;
    logic       flash_done = 1'b0;
    logic       buf_load, buf_abort, rww_busy, halt_core;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_global_en(irq_global_en), .irq(irq),
        .spm_strobe(spm_strobe), .lpm_strobe(lpm_strobe), .ptr_page(ptr_page),
        .ptr_lsb(ptr_lsb), .lock_bits(lock_bits), .fuse_bits(fuse_bits),
        .lpm_hit(lpm_hit), .lpm_data(lpm_data), .flash_start(flash_start),
        .flash_op(flash_op), .flash_page(flash_page), .flash_done(flash_done),
        .buf_load(buf_load), .buf_abort(buf_abort), .rww_busy(rww_busy),
        .halt_core(halt_core)
    );

    typedef struct packed {
        logic [7:0] wdata;
        logic [2:0] delay;
        logic [8:0] page;
        logic       exp_start;
        logic [2:0] exp_op;
        logic       exp_busy;
        logic       exp_halt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'h03, 3'd1, 9'd2,   1'b1, 3'b001, 1'b1, 1'b0},
        '{8'h05, 3'd4, 9'd3,   1'b1, 3'b010, 1'b1, 1'b0},
        '{8'h05, 3'd2, 9'd480, 1'b1, 3'b010, 1'b0, 1'b1},
        '{8'h03, 3'd3, 9'd480, 1'b1, 3'b001, 1'b0, 1'b0},
        '{8'h03, 3'd5, 9'd2,   1'b0, 3'b000, 1'b0, 1'b0},
        '{8'h09, 3'd2, 9'd2,   1'b1, 3'b100, 1'b0, 1'b0},
        '{8'h07, 3'd1, 9'd5,   1'b1, 3'b001, 1'b1, 1'b0},
        '{8'h0D, 3'd1, 9'd5,   1'b1, 3'b010, 1'b1, 1'b0},
        '{8'h19, 3'd1, 9'd5,   1'b1, 3'b100, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        reg_we = 1'b0;
        spm_strobe = 1'b0;
        lpm_strobe = 1'b0;
        flash_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic strobe_after(input int d);
        for (int i = 1; i < d; i++) @(negedge clk);
        spm_strobe = 1'b1;
        @(negedge clk);
        spm_strobe = 1'b0;
    endtask

    task automatic done_pulse();
        flash_done = 1'b1;
        @(negedge clk);
        flash_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state and reserved bit
        chk("R1", "reset rdata", reg_rdata, 8'h00);
        chk("R1", "reset outputs", {irq, flash_start, buf_load, rww_busy, halt_core}, 5'b0);
        wr(8'hA0);
        chk("R1", "reserved bit", reg_rdata, 8'h80);

        // R2: interrupt gating
        irq_global_en = 1'b1;
        #1;
        chk("R2", "irq ie set en clear", irq, 1'b1);
        irq_global_en = 1'b0;
        #1;
        chk("R2", "irq global off", irq, 1'b0);
        irq_global_en = 1'b1;
        wr(8'h81);
        chk("R2", "irq while enabled", irq, 1'b0);
        repeat (3) @(negedge clk);
        chk("R3", "load armed at last window cycle", reg_rdata, 8'h81);
        @(negedge clk);
        chk("R3", "expired load", reg_rdata, 8'h80);
        chk("R2", "irq after expiry", irq, 1'b1);
        irq_global_en = 1'b0;

        // R3: command expiry then late strobe ignored
        do_reset();
        wr(8'h03);
        repeat (3) @(negedge clk);
        chk("R3", "erase armed cycle 3", reg_rdata, 8'h03);
        @(negedge clk);
        chk("R3", "erase expired", reg_rdata, 8'h00);
        strobe_after(1);
        chk("R3", "late strobe start", flash_start, 1'b0);

        // table: single commands with varying strobe delay
        for (int v = 0; v < NV; v++) begin
            do_reset();
            ptr_page = VEC[v].page;
            wr(VEC[v].wdata);
            strobe_after(int'(VEC[v].delay));
            chk("R3", $sformatf("vec%0d start", v), flash_start, VEC[v].exp_start);
            if (VEC[v].exp_start) begin
                chk("R4", $sformatf("vec%0d op", v), flash_op, VEC[v].exp_op);
                chk("R4", $sformatf("vec%0d rdata cmd", v), reg_rdata[3:0],
                    {VEC[v].exp_op, 1'b1});
                chk("R6", $sformatf("vec%0d page", v), flash_page, VEC[v].page);
            end else begin
                chk("R3", $sformatf("vec%0d cleared", v), reg_rdata[4:0], 5'b0);
            end
            chk("R6", $sformatf("vec%0d busy", v), rww_busy, VEC[v].exp_busy);
            chk("R11", $sformatf("vec%0d halt", v), halt_core, VEC[v].exp_halt);
            if (VEC[v].exp_start) begin
                done_pulse();
                chk("R5", $sformatf("vec%0d done clears", v), reg_rdata[4:0], 5'b0);
                chk("R11", $sformatf("vec%0d halt off", v), halt_core, 1'b0);
            end
        end

        // R8: read re-enable during running erase is ignored
        do_reset();
        ptr_page = 9'd2;
        wr(8'h03);
        strobe_after(1);
        wr(8'h11);
        chk("R8", "write during run", reg_rdata, 8'h43);
        strobe_after(1);
        chk("R8", "busy kept", rww_busy, 1'b1);
        done_pulse();
        chk("R5", "erase done", reg_rdata, 8'h40);

        // R7: read re-enable after completion clears busy
        wr(8'h11);
        chk("R7", "reen armed", reg_rdata, 8'h51);
        strobe_after(2);
        chk("R7", "reen clears busy", reg_rdata, 8'h00);

        // R7: buffer load clears busy
        wr(8'h03);
        strobe_after(1);
        done_pulse();
        chk("R6", "busy before load", rww_busy, 1'b1);
        wr(8'h01);
        strobe_after(1);
        chk("R7", "load pulse", buf_load, 1'b1);
        chk("R7", "load clears busy", reg_rdata, 8'h00);

        // R9: abort of armed load
        wr(8'h01);
        wr(8'h10);
        chk("R9", "abort pulse", buf_abort, 1'b1);
        chk("R9", "abort rdata", reg_rdata, 8'h00);
        strobe_after(1);
        chk("R9", "no load after abort", buf_load, 1'b0);

        // R10: lock/fuse reads
        do_reset();
        wr(8'h09);
        ptr_lsb = 1'b1;
        lpm_strobe = 1'b1;
        @(negedge clk);
        lpm_strobe = 1'b0;
        chk("R10", "fuse hit", lpm_hit, 1'b1);
        chk("R10", "fuse data", lpm_data, 8'hA5);
        wr(8'h09);
        ptr_lsb = 1'b0;
        repeat (2) @(negedge clk);
        lpm_strobe = 1'b1;
        @(negedge clk);
        lpm_strobe = 1'b0;
        chk("R10", "lock data", lpm_data, 8'h3C);
        wr(8'h09);
        repeat (3) @(negedge clk);
        lpm_strobe = 1'b1;
        @(negedge clk);
        lpm_strobe = 1'b0;
        chk("R10", "late load no hit", lpm_hit, 1'b0);
        repeat (2) @(negedge clk);

        finish_run();
    end
endmodule